// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block carries out the entry steps of a software coprocessor-trap instruction for a processor core that runs in either a compatibility (emulation) mode or a wide (native) mode. A single start pulse hands it the current program counter, status byte, stack pointer and mode bit. The sequencer advances the return address by two, writes that address and then the unchanged status byte to a descending stack, and fetches the new program counter from a vector location that depends on the mode. It owns one byte-wide synchronous memory port for the whole sequence.

On completion it raises a one-cycle done pulse. In that cycle the new program counter, the updated status byte (interrupt-disable forced on, decimal mode forced off) and the final stack pointer are on its outputs. They stay there until the next sequence starts. The core keeps its own registers while the sequencer runs and takes the results when it sees done.

The state machine walks through seven named states. IDLE goes to PUSH_HI on start. PUSH_HI goes to PUSH_LO, PUSH_LO goes to PUSH_ST, PUSH_ST goes to FETCH_LO and FETCH_LO goes to FETCH_HI, each of these steps taken on the cycle the memory reports ready. FETCH_HI goes to FINISH on ready, and FINISH always returns to IDLE after one cycle.

Top module: `swi_entry_seq`

## Requirements
- R1: After reset the block is idle: mem_req and done are 0, and pc_out, status_out and sp_out are all zero.
- R2: The saved return address is pc_in plus 2, modulo 2^16, so 0xFFFF saves as 0x0001.
- R3: The three stack writes come in a fixed order with mem_we=1. The first puts the return address high byte at sp_in, the second puts the low byte at sp_in-1, and the third puts status_in, unmodified, at sp_in-2. Addresses wrap modulo 2^16.
- R4: At done, sp_out equals sp_in minus 3, modulo 2^16.
- R5: At done, status_out equals status_in with bit 2 (interrupt disable) set to 1 and bit 3 (decimal mode) cleared to 0, and the other bits unchanged.
- R6: After the writes come two reads with mem_we=0. With emu_mode=1 they go to 0xFFF4 and then 0xFFF5; with emu_mode=0 they go to 0xFFE4 and then 0xFFE5. pc_out is {second byte, first byte}.
- R7: Each access keeps mem_req high with mem_addr, mem_we and mem_wdata stable until mem_ready is seen, and the sequence steps forward on exactly that cycle, so no access is repeated or lost.
- R8: done is high for exactly one cycle, with the results valid in that cycle. pc_out, status_out and sp_out then hold their values until a new start.
- R9: A start pulse that arrives while a sequence is running has no effect on that sequence's accesses or results.
- R10: A sequence makes exactly five memory accesses, and mem_req is 0 while the block is idle or signalling done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a trap entry sequence (taken only when idle) |
| pc_in | input | 16 | Program counter at the trap instruction |
| status_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| emu_mode | input | 1 | 1 selects the emulation-mode vector, 0 the native one |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter from the vector |
| status_out | output | 8 | Status with interrupt disable set and decimal cleared |
| sp_out | output | 16 | Stack pointer after the three pushes |

## Verification
The bench builds the block with its default parameters: a byte data path, a 16-bit word, the vectors at 0xFFF4 and 0xFFE4, and the flags at bits 2 and 3. With these values both vector locations can be reached from the mode input. A stack pointer of 0x0001 and a program counter of 0xFFFF are also reachable, which lets the bench see the wrap of the pushes through address zero and the wrap of the return address within one sequence. The memory model answers after zero to three wait cycles, so the request hold and the one-step-per-ready rule are tested with both immediate and delayed answers.

// File: rtl/swi_pkg.sv
package swi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_HI  = 3'd1,
        ST_PUSH_LO  = 3'd2,
        ST_PUSH_ST  = 3'd3,
        ST_FETCH_LO = 3'd4,
        ST_FETCH_HI = 3'd5,
        ST_FINISH   = 3'd6
    } swi_state_e;

endpackage

// File: rtl/swi_seq_fsm.sv
module swi_seq_fsm
    import swi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mem_ready,
    output swi_state_e state,
    output logic       mem_req,
    output logic       mem_we,
    output logic       done
);

    swi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)     state_d = ST_PUSH_HI;
            ST_PUSH_HI:  if (mem_ready) state_d = ST_PUSH_LO;
            ST_PUSH_LO:  if (mem_ready) state_d = ST_PUSH_ST;
            ST_PUSH_ST:  if (mem_ready) state_d = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_ready) state_d = ST_FETCH_HI;
            ST_FETCH_HI: if (mem_ready) state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FETCH_LO, ST_FETCH_HI: mem_req = 1'b1;
            ST_FINISH:                done    = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/swi_ctx_path.sv
module swi_ctx_path
    import swi_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [2*DATA_W-1:0] VEC_EMU = 16'hFFF4,
    parameter logic [2*DATA_W-1:0] VEC_NAT = 16'hFFE4,
    parameter int                IDIS_BIT = 2,
    parameter int                DEC_BIT  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  swi_state_e          state,
    input  logic                start,
    input  logic                mem_ready,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [2*DATA_W-1:0] sp_in,
    input  logic                emu_mode,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   status_out,
    output logic [2*DATA_W-1:0] sp_out
);

    localparam int WORD_W = 2 * DATA_W;
    localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(2);
    localparam logic [WORD_W-1:0] ONE     = WORD_W'(1);

    logic [WORD_W-1:0] ret_pc_q, sp_q, pc_q;
    logic [DATA_W-1:0] stat_q, stat_upd, vec_lo_q, stat_out_q;
    logic              emu_q;
    logic [WORD_W-1:0] vec_base;

    wire take      = (state == ST_IDLE) && start;
    wire push_step = mem_ready && (state == ST_PUSH_HI || state == ST_PUSH_LO ||
                                   state == ST_PUSH_ST);

    // Per-bit status update: one flag forced on, one forced off, the rest kept.
    for (genvar b = 0; b < DATA_W; b++) begin : g_flag
        if (b == IDIS_BIT) begin : g_set
            assign stat_upd[b] = 1'b1;
        end else if (b == DEC_BIT) begin : g_clr
            assign stat_upd[b] = 1'b0;
        end else begin : g_keep
            assign stat_upd[b] = stat_q[b];
        end
    end

    assign vec_base = emu_q ? VEC_EMU : VEC_NAT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_pc_q   <= '0;
            sp_q       <= '0;
            stat_q     <= '0;
            emu_q      <= 1'b0;
            vec_lo_q   <= '0;
            pc_q       <= '0;
            stat_out_q <= '0;
        end else begin
            if (take) begin
                ret_pc_q <= pc_in + PC_STEP;
                sp_q     <= sp_in;
                stat_q   <= status_in;
                emu_q    <= emu_mode;
            end
            if (push_step) sp_q <= sp_q - ONE;
            if (state == ST_PUSH_ST && mem_ready) stat_out_q <= stat_upd;
            if (state == ST_FETCH_LO && mem_ready) vec_lo_q <= mem_rdata;
            if (state == ST_FETCH_HI && mem_ready) pc_q <= {mem_rdata, vec_lo_q};
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_HI: begin
                mem_addr  = sp_q;
                mem_wdata = ret_pc_q[WORD_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                mem_addr  = sp_q;
                mem_wdata = ret_pc_q[DATA_W-1:0];
            end
            ST_PUSH_ST: begin
                mem_addr  = sp_q;
                mem_wdata = stat_q;
            end
            ST_FETCH_LO: mem_addr = vec_base;
            ST_FETCH_HI: mem_addr = vec_base + ONE;
            default: ;
        endcase
    end

    assign pc_out     = pc_q;
    assign status_out = stat_out_q;
    assign sp_out     = sp_q;

endmodule

// File: rtl/swi_entry_seq.sv
module swi_entry_seq
    import swi_pkg::*;
#(
    parameter int                  DATA_W   = 8,
    parameter logic [2*DATA_W-1:0] VEC_EMU  = 16'hFFF4,
    parameter logic [2*DATA_W-1:0] VEC_NAT  = 16'hFFE4,
    parameter int                  IDIS_BIT = 2,
    parameter int                  DEC_BIT  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [2*DATA_W-1:0] sp_in,
    input  logic                emu_mode,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ready,
    output logic                done,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   status_out,
    output logic [2*DATA_W-1:0] sp_out
);

    swi_state_e state;

    swi_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ready (mem_ready),
        .state     (state),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .done      (done)
    );

    swi_ctx_path #(
        .DATA_W   (DATA_W),
        .VEC_EMU  (VEC_EMU),
        .VEC_NAT  (VEC_NAT),
        .IDIS_BIT (IDIS_BIT),
        .DEC_BIT  (DEC_BIT)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .start      (start),
        .mem_ready  (mem_ready),
        .pc_in      (pc_in),
        .status_in  (status_in),
        .sp_in      (sp_in),
        .emu_mode   (emu_mode),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .pc_out     (pc_out),
        .status_out (status_out),
        .sp_out     (sp_out)
    );

endmodule

// File: rtl/swi_entry_seq_chk.sv
module swi_entry_seq_chk #(
    parameter int                  DATA_W   = 8,
    parameter logic [2*DATA_W-1:0] VEC_EMU  = 16'hFFF4,
    parameter logic [2*DATA_W-1:0] VEC_NAT  = 16'hFFE4,
    parameter int                  IDIS_BIT = 2,
    parameter int                  DEC_BIT  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_req,
    input logic                mem_we,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                mem_ready,
    input logic                done,
    input logic [DATA_W-1:0]   status_out
);

    localparam logic [2*DATA_W-1:0] ONE = (2*DATA_W)'(1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R10

    AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[IDIS_BIT] && !status_out[DEC_BIT])); // R5

    AST_READ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr == VEC_EMU || mem_addr == VEC_EMU + ONE ||
                                  mem_addr == VEC_NAT || mem_addr == VEC_NAT + ONE)); // R6

endmodule

bind swi_entry_seq swi_entry_seq_chk #(
    .DATA_W   (DATA_W),
    .VEC_EMU  (VEC_EMU),
    .VEC_NAT  (VEC_NAT),
    .IDIS_BIT (IDIS_BIT),
    .DEC_BIT  (DEC_BIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .done       (done),
    .status_out (status_out)
);

// File: tb/swi_entry_seq_tb_top.sv
module swi_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [15:0] sp_in = '0;
    logic        emu_mode = 1'b0;
    logic        mem_req, mem_we, done;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, status_out;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    // memory model state
    int          wait_cycles = 0;
    int          wcnt = 0;
    logic [7:0]  seed = '0;
    logic [15:0] log_addr [0:15];
    logic        log_we   [0:15];
    logic [7:0]  log_data [0:15];
    int          log_n = 0;

    always #2.5 clk = ~clk;

    swi_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
        .status_in(status_in), .sp_in(sp_in), .emu_mode(emu_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .pc_out(pc_out), .status_out(status_out), .sp_out(sp_out)
    );

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cycles) begin
                mem_ready = 1'b1;
                mem_rdata = mem_addr[7:0] ^ seed;
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_data[log_n] = mem_wdata;
                end
                log_n++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 0);
        check(pc_out == 16'h0, "R1", "pc_out after reset", 32'(pc_out), 0);
        check(status_out == 8'h0, "R1", "status_out after reset", 32'(status_out), 0);
        check(sp_out == 16'h0, "R1", "sp_out after reset", 32'(sp_out), 0);
    endtask

    // Runs one sequence; optionally pulses start again while it is busy (R9).
    task automatic run_seq(input logic [15:0] pc, input logic [7:0] st,
                           input logic [15:0] sp, input logic emu,
                           input logic [7:0] sd, input int wt, input bit poke);
        logic [15:0] ret, vec, exp_pc, exp_sp;
        logic [7:0]  exp_st;
        int          cyc;
        int          done_seen;
        ret    = pc + 16'd2;
        vec    = emu ? 16'hFFF4 : 16'hFFE4;
        exp_pc = {(vec[7:0] + 8'd1) ^ sd, vec[7:0] ^ sd};
        exp_sp = sp - 16'd3;
        exp_st = (st | 8'h04) & ~8'h08;
        @(negedge clk);
        wait_cycles = wt; seed = sd; log_n = 0;
        pc_in = pc; status_in = st; sp_in = sp; emu_mode = emu; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; done_seen = 0;
        while (!done && cyc < 200) begin
            check(done == 1'b0, "R8", "done early", 32'(done), 0);
            if (poke && cyc == 3) begin
                pc_in = 16'hA5A5; status_in = 8'h33; sp_in = 16'h0F00;
                emu_mode = ~emu; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done == 1'b1, "R8", "done reached", 32'(done), 1);
        check(mem_req == 1'b0, "R10", "no request at done", 32'(mem_req), 0);
        check(log_n == 5, "R10", "access count", 32'(log_n), 5);
        if (log_n == 5) begin
            check(log_addr[0] == sp && log_we[0], "R3", "push hi addr", 32'(log_addr[0]), 32'(sp));
            check(log_data[0] == ret[15:8], "R2", "push hi data", 32'(log_data[0]), 32'(ret[15:8]));
            check(log_addr[1] == sp - 16'd1 && log_we[1], "R3", "push lo addr", 32'(log_addr[1]), 32'(sp - 16'd1));
            check(log_data[1] == ret[7:0], "R2", "push lo data", 32'(log_data[1]), 32'(ret[7:0]));
            check(log_addr[2] == sp - 16'd2 && log_we[2], "R3", "push status addr", 32'(log_addr[2]), 32'(sp - 16'd2));
            check(log_data[2] == st, "R3", "pushed status", 32'(log_data[2]), 32'(st));
            check(log_addr[3] == vec && !log_we[3], "R6", "vector low read", 32'(log_addr[3]), 32'(vec));
            check(log_addr[4] == vec + 16'd1 && !log_we[4], "R6", "vector high read", 32'(log_addr[4]), 32'(vec + 16'd1));
        end
        check(pc_out == exp_pc, "R6", "pc_out", 32'(pc_out), 32'(exp_pc));
        check(sp_out == exp_sp, "R4", "sp_out", 32'(sp_out), 32'(exp_sp));
        check(status_out == exp_st, "R5", "status_out", 32'(status_out), 32'(exp_st));
        if (poke) check(log_n == 5, "R9", "busy start ignored", 32'(log_n), 5);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) done_seen++;
            check(mem_req == 1'b0, "R10", "idle request", 32'(mem_req), 0);
        end
        check(done_seen == 0, "R8", "done single pulse", 32'(done_seen), 0);
        check(pc_out == exp_pc && sp_out == exp_sp && status_out == exp_st,
              "R8", "outputs held", 32'(pc_out), 32'(exp_pc));
        check(log_n == 5, "R7", "no repeated access", 32'(log_n), 5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_seq(16'h1234, 8'h00, 16'h01FF, 1'b1, 8'h00, 0, 1'b0);
        run_seq(16'h8000, 8'hFF, 16'h1FFF, 1'b0, 8'h5A, 2, 1'b0);
        run_seq(16'hFFFF, 8'h08, 16'h0001, 1'b1, 8'hC3, 1, 1'b0);
        run_seq(16'h4321, 8'h81, 16'h0300, 1'b0, 8'h17, 3, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule